// File: doc/BRIEF.md
# Update-Propagating Coherence Line Controller

This block holds the coherence state of one line in a writeback cache whose sharers are kept consistent by broadcasting each written word to the other holders, rather than invalidating their copies. The line is in one of five states: not present, exclusive clean, shared clean, shared owner (dirty and responsible for the eventual writeback), or exclusive dirty. The surrounding cache classifies each processor access as a read hit, write hit, read miss, write miss or eviction and presents it to the controller. The controller answers with a bus command, a word offset and a data payload, and it samples the wired-OR shared line during that command.

On the snoop side, the controller watches bus reads and word updates issued by other caches. When it holds a copy it drives the shared line. When it holds a dirty copy and another cache reads, it raises a flush strobe so that the data array sources the line. When an update arrives for a shared copy, it raises a merge strobe that carries the word offset and data to be written into the local array. The data array and the bus arbiter sit outside the block. A snoop always takes precedence over a processor request in the same cycle.

Top module: `coh_upd_line_ctrl`

## Requirements
- R1: After synchronous reset the line state is not present (encoding 0). The bus command is idle (0), no strobe is high, and `cpu_busy` is low. State encodings: 0 not present, 1 exclusive clean, 2 shared clean, 3 shared owner, 4 exclusive dirty.
- R2: A read miss (op 3) in the not-present state issues a bus read (command 1) in the same cycle and fills the line as shared clean if `bus_shared_in` is high, otherwise as exclusive clean.
- R3: A write hit (op 2) in exclusive clean or exclusive dirty moves the line to exclusive dirty with no bus command. A read hit (op 1) changes nothing and issues no command.
- R4: A write hit in shared clean or shared owner issues a bus update (command 2) that carries `cpu_off` and `cpu_data`. The line becomes shared owner if `bus_shared_in` is high, otherwise exclusive dirty.
- R5: A write miss (op 4) in the not-present state issues a bus read. If `bus_shared_in` is low, the line becomes exclusive dirty. If it is high, the line becomes shared owner, and in the next cycle the block issues a bus update that carries the offset and data captured with the miss, with `cpu_busy` high throughout that cycle.
- R6: A snooped bus read (snoop code 1) asserts `snp_shared_out` whenever the line is present. It raises `snp_flush` in shared owner and exclusive dirty. Exclusive dirty then moves to shared owner, and exclusive clean moves to shared clean.
- R7: A snooped update (snoop code 2) on a shared clean or shared owner line raises `merge_en` with `snp_off` and `snp_data` on the merge outputs, asserts `snp_shared_out`, and leaves the line shared clean. In any other state it is ignored: no strobe is raised and the state is kept.
- R8: Eviction (op 5) of a shared owner or exclusive dirty line issues a writeback (command 3). Eviction of a clean line issues nothing. In both cases the line becomes not present.
- R9: While a snoop code is non-zero, or while the second cycle of a shared write miss is in progress, `cpu_busy` is high and the processor op is discarded. During that second cycle a snoop gets no response.
- R10: An op that does not fit the state is ignored with no command and no state change. This covers a hit in the not-present state and a miss in a present state. While no update is on the bus, `bus_off` and `bus_data` read zero, and while `merge_en` is low, the merge outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_op | input | 3 | Processor access: 0 none, 1 read hit, 2 write hit, 3 read miss, 4 write miss, 5 evict |
| cpu_off | input | OFF_W | Word offset of a processor write |
| cpu_data | input | DATA_W | Word written by the processor |
| cpu_busy | output | 1 | Processor op is not taken this cycle |
| bus_cmd | output | 2 | 0 idle, 1 read, 2 word update, 3 writeback |
| bus_off | output | OFF_W | Word offset carried by an update |
| bus_data | output | DATA_W | Word carried by an update |
| bus_shared_in | input | 1 | Wired-OR shared response to this block's command |
| snp_cmd | input | 2 | Snooped command: 0 none, 1 read, 2 word update |
| snp_off | input | OFF_W | Offset of a snooped update |
| snp_data | input | DATA_W | Word of a snooped update |
| snp_shared_out | output | 1 | This cache holds the snooped line |
| snp_flush | output | 1 | Source the dirty line for the snooped read |
| merge_en | output | 1 | Write the snooped word into the local line |
| merge_off | output | OFF_W | Offset for the local merge |
| merge_data | output | DATA_W | Word for the local merge |
| line_state | output | 3 | Current coherence state |

## Verification
Properties check the following on every cycle: a flush is always followed by the shared owner state, a merge is always followed by shared clean, a writeback always leaves the line not present, and bus reads are issued only from the not-present state. They also check that the shared output is silent for an absent line, that any snoop makes the processor port busy, and that an update's outcome follows the shared response. The exact payloads, the capture of write-miss data for the delayed update, and the discarding of ops that do not fit the state are shown only by the bench's scenarios. Those scenarios run a reference model over directed sequences and random traffic.

// File: rtl/coh_upd_pkg.sv
package coh_upd_pkg;

    typedef enum logic [2:0] {
        LS_INV   = 3'd0,
        LS_EXCL  = 3'd1,
        LS_SHCLN = 3'd2,
        LS_SHOWN = 3'd3,
        LS_DIRTY = 3'd4
    } line_st_e;

    typedef enum logic [2:0] {
        CPU_NONE    = 3'd0,
        CPU_RD_HIT  = 3'd1,
        CPU_WR_HIT  = 3'd2,
        CPU_RD_MISS = 3'd3,
        CPU_WR_MISS = 3'd4,
        CPU_EVICT   = 3'd5
    } cpu_op_e;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_RD   = 2'd1,
        BUS_UPD  = 2'd2,
        BUS_WB   = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        SNP_NONE = 2'd0,
        SNP_RD   = 2'd1,
        SNP_UPD  = 2'd2
    } snp_cmd_e;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_WM_UPD = 1'b1
    } phase_e;

    typedef struct packed {
        line_st_e nxt;
        bus_cmd_e cmd;
        logic     use_pend;
        logic     load_pend;
        phase_e   ph;
    } cpu_dec_t;

    typedef struct packed {
        line_st_e nxt;
        logic     shared;
        logic     flush;
        logic     merge;
    } snp_dec_t;

    function automatic logic st_present(line_st_e s);
        return s != LS_INV;
    endfunction

    function automatic logic st_owner(line_st_e s);
        return (s == LS_SHOWN) || (s == LS_DIRTY);
    endfunction

    function automatic logic st_shared(line_st_e s);
        return (s == LS_SHCLN) || (s == LS_SHOWN);
    endfunction

endpackage

// File: rtl/coh_upd_snoop_resp.sv
module coh_upd_snoop_resp
    import coh_upd_pkg::*;
(
    input  line_st_e st,
    input  snp_cmd_e scmd,
    input  logic     en,
    output snp_dec_t dec
);
    always_comb begin
        dec.nxt    = st;
        dec.shared = 1'b0;
        dec.flush  = 1'b0;
        dec.merge  = 1'b0;
        if (en) begin
            unique case (scmd)
                SNP_RD: begin
                    dec.shared = st_present(st);
                    dec.flush  = st_owner(st);
                    if (st == LS_DIRTY) dec.nxt = LS_SHOWN;
                    if (st == LS_EXCL)  dec.nxt = LS_SHCLN;
                end
                SNP_UPD: begin
                    if (st_shared(st)) begin
                        dec.merge  = 1'b1;
                        dec.shared = 1'b1;
                        dec.nxt    = LS_SHCLN;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/coh_upd_cpu_seq.sv
module coh_upd_cpu_seq
    import coh_upd_pkg::*;
(
    input  line_st_e st,
    input  phase_e   ph,
    input  cpu_op_e  op,
    input  logic     go,
    input  logic     shared_in,
    output cpu_dec_t dec
);
    always_comb begin
        dec.nxt       = st;
        dec.cmd       = BUS_IDLE;
        dec.use_pend  = 1'b0;
        dec.load_pend = 1'b0;
        dec.ph        = PH_IDLE;
        if (ph == PH_WM_UPD) begin
            dec.cmd      = BUS_UPD;
            dec.use_pend = 1'b1;
            dec.nxt      = LS_SHOWN;
        end else if (go) begin
            unique case (op)
                CPU_WR_HIT: begin
                    if (st == LS_EXCL || st == LS_DIRTY) begin
                        dec.nxt = LS_DIRTY;
                    end else if (st_shared(st)) begin
                        dec.cmd = BUS_UPD;
                        dec.nxt = shared_in ? LS_SHOWN : LS_DIRTY;
                    end
                end
                CPU_RD_MISS: begin
                    if (st == LS_INV) begin
                        dec.cmd = BUS_RD;
                        dec.nxt = shared_in ? LS_SHCLN : LS_EXCL;
                    end
                end
                CPU_WR_MISS: begin
                    if (st == LS_INV) begin
                        dec.cmd = BUS_RD;
                        if (shared_in) begin
                            dec.nxt       = LS_SHOWN;
                            dec.ph        = PH_WM_UPD;
                            dec.load_pend = 1'b1;
                        end else begin
                            dec.nxt = LS_DIRTY;
                        end
                    end
                end
                CPU_EVICT: begin
                    if (st_owner(st)) dec.cmd = BUS_WB;
                    dec.nxt = LS_INV;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/coh_upd_pend_buf.sv
module coh_upd_pend_buf #(
    parameter int OFF_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [OFF_W-1:0]  off_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [OFF_W-1:0]  off_q,
    output logic [DATA_W-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            off_q  <= '0;
            data_q <= '0;
        end else if (load) begin
            off_q  <= off_in;
            data_q <= data_in;
        end
    end
endmodule

// File: rtl/coh_upd_line_ctrl.sv
module coh_upd_line_ctrl
    import coh_upd_pkg::*;
#(
    parameter  int WORDS_PER_LINE = 8,
    parameter  int DATA_W         = 32,
    localparam int OFF_W          = $clog2(WORDS_PER_LINE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cpu_op,
    input  logic [OFF_W-1:0]  cpu_off,
    input  logic [DATA_W-1:0] cpu_data,
    output logic              cpu_busy,
    output logic [1:0]        bus_cmd,
    output logic [OFF_W-1:0]  bus_off,
    output logic [DATA_W-1:0] bus_data,
    input  logic              bus_shared_in,
    input  logic [1:0]        snp_cmd,
    input  logic [OFF_W-1:0]  snp_off,
    input  logic [DATA_W-1:0] snp_data,
    output logic              snp_shared_out,
    output logic              snp_flush,
    output logic              merge_en,
    output logic [OFF_W-1:0]  merge_off,
    output logic [DATA_W-1:0] merge_data,
    output logic [2:0]        line_state
);
    line_st_e          st_q, st_d;
    phase_e            ph_q;
    cpu_dec_t          cdec;
    snp_dec_t          sdec;
    logic              snoop_act, cpu_go;
    logic [OFF_W-1:0]  pend_off;
    logic [DATA_W-1:0] pend_data;
    cpu_op_e           op_e;
    snp_cmd_e          scmd_e;

    assign op_e      = cpu_op_e'(cpu_op);
    assign scmd_e    = snp_cmd_e'(snp_cmd);
    assign snoop_act = (ph_q == PH_IDLE) && (scmd_e != SNP_NONE);
    assign cpu_busy  = (ph_q != PH_IDLE) || (scmd_e != SNP_NONE);
    assign cpu_go    = !cpu_busy && (op_e != CPU_NONE);

    coh_upd_snoop_resp u_snoop (
        .st   (st_q),
        .scmd (scmd_e),
        .en   (snoop_act),
        .dec  (sdec)
    );

    coh_upd_cpu_seq u_seq (
        .st        (st_q),
        .ph        (ph_q),
        .op        (op_e),
        .go        (cpu_go),
        .shared_in (bus_shared_in),
        .dec       (cdec)
    );

    coh_upd_pend_buf #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .load    (cdec.load_pend),
        .off_in  (cpu_off),
        .data_in (cpu_data),
        .off_q   (pend_off),
        .data_q  (pend_data)
    );

    assign st_d = snoop_act ? sdec.nxt : cdec.nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= LS_INV;
            ph_q <= PH_IDLE;
        end else begin
            st_q <= st_d;
            ph_q <= snoop_act ? PH_IDLE : cdec.ph;
        end
    end

    always_comb begin
        bus_off  = '0;
        bus_data = '0;
        if (cdec.cmd == BUS_UPD) begin
            bus_off  = cdec.use_pend ? pend_off  : cpu_off;
            bus_data = cdec.use_pend ? pend_data : cpu_data;
        end
    end

    assign bus_cmd        = cdec.cmd;
    assign snp_shared_out = sdec.shared;
    assign snp_flush      = sdec.flush;
    assign merge_en       = sdec.merge;
    assign merge_off      = sdec.merge ? snp_off  : '0;
    assign merge_data     = sdec.merge ? snp_data : '0;
    assign line_state     = st_q;
endmodule

// File: rtl/coh_upd_line_ctrl_chk.sv
module coh_upd_line_ctrl_chk
    import coh_upd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] cpu_op,
    input logic       cpu_busy,
    input logic [1:0] bus_cmd,
    input logic       bus_shared_in,
    input logic [1:0] snp_cmd,
    input logic       snp_shared_out,
    input logic       snp_flush,
    input logic       merge_en,
    input logic [2:0] line_state
);
    a_r1_shared_needs_copy: assert property (@(posedge clk) disable iff (rst)
        snp_shared_out |-> (line_state != 3'(LS_INV)));

    a_r2_read_from_absent: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == 2'(BUS_RD)) |-> (line_state == 3'(LS_INV)));

    a_r2_fill_shared: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == 2'(BUS_RD) && cpu_op == 3'(CPU_RD_MISS) && bus_shared_in)
        |=> (line_state == 3'(LS_SHCLN)));

    a_r4_upd_kept_shared: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == 2'(BUS_UPD) && !cpu_busy && bus_shared_in)
        |=> (line_state == 3'(LS_SHOWN)));

    a_r4_upd_alone: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == 2'(BUS_UPD) && !cpu_busy && !bus_shared_in)
        |=> (line_state == 3'(LS_DIRTY)));

    a_r5_delayed_upd_owner: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == 2'(BUS_UPD) && cpu_busy) |=> (line_state == 3'(LS_SHOWN)));

    a_r6_flush_leaves_owner: assert property (@(posedge clk) disable iff (rst)
        snp_flush |=> (line_state == 3'(LS_SHOWN)));

    a_r7_merge_to_clean: assert property (@(posedge clk) disable iff (rst)
        merge_en |=> (line_state == 3'(LS_SHCLN)));

    a_r8_wb_drops_line: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == 2'(BUS_WB)) |=> (line_state == 3'(LS_INV)));

    a_r9_snoop_blocks_cpu: assert property (@(posedge clk) disable iff (rst)
        (snp_cmd != 2'(SNP_NONE)) |-> cpu_busy);
endmodule

bind coh_upd_line_ctrl coh_upd_line_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .cpu_op         (cpu_op),
    .cpu_busy       (cpu_busy),
    .bus_cmd        (bus_cmd),
    .bus_shared_in  (bus_shared_in),
    .snp_cmd        (snp_cmd),
    .snp_shared_out (snp_shared_out),
    .snp_flush      (snp_flush),
    .merge_en       (merge_en),
    .line_state     (line_state)
);

// File: tb/coh_upd_line_ctrl_tb.sv
module coh_upd_line_ctrl_tb;
    localparam int CLK_P  = 10;
    localparam int WORDS  = 8;
    localparam int DW     = 32;
    localparam int OW     = $clog2(WORDS);

    localparam int S_INV = 0, S_EXCL = 1, S_SHC = 2, S_SHO = 3, S_DRT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0]    cpu_op = '0;
    logic [OW-1:0] cpu_off = '0;
    logic [DW-1:0] cpu_data = '0;
    logic          cpu_busy;
    logic [1:0]    bus_cmd;
    logic [OW-1:0] bus_off;
    logic [DW-1:0] bus_data;
    logic          bus_shared_in = 1'b0;
    logic [1:0]    snp_cmd = '0;
    logic [OW-1:0] snp_off = '0;
    logic [DW-1:0] snp_data = '0;
    logic          snp_shared_out, snp_flush, merge_en;
    logic [OW-1:0] merge_off;
    logic [DW-1:0] merge_data;
    logic [2:0]    line_state;

    always #(CLK_P/2) clk = ~clk;

    coh_upd_line_ctrl #(.WORDS_PER_LINE(WORDS), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .cpu_op(cpu_op), .cpu_off(cpu_off), .cpu_data(cpu_data),
        .cpu_busy(cpu_busy), .bus_cmd(bus_cmd), .bus_off(bus_off), .bus_data(bus_data),
        .bus_shared_in(bus_shared_in), .snp_cmd(snp_cmd), .snp_off(snp_off),
        .snp_data(snp_data), .snp_shared_out(snp_shared_out), .snp_flush(snp_flush),
        .merge_en(merge_en), .merge_off(merge_off), .merge_data(merge_data),
        .line_state(line_state)
    );

    int n_chk = 0;
    int n_fail = 0;

    int m_st = S_INV;
    int m_ph = 0;
    logic [OW-1:0] m_poff = '0;
    logic [DW-1:0] m_pdata = '0;
    string prev_tag = "R1";

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit is_owner(int s);
        return s == S_SHO || s == S_DRT;
    endfunction

    // Applies one cycle of stimulus, checks outputs against the model, advances the model.
    task automatic step(input int op, input int off, input logic [DW-1:0] dat, input bit sh,
                        input int sc, input int soff, input logic [DW-1:0] sdat);
        int nx, nph, e_cmd;
        bit e_busy, e_sh, e_fl, e_mg;
        longint e_boff, e_bdat, e_moff, e_mdat;
        string tag;
        @(posedge clk);
        #1;
        cpu_op = 3'(op); cpu_off = OW'(off); cpu_data = dat; bus_shared_in = sh;
        snp_cmd = 2'(sc); snp_off = OW'(soff); snp_data = sdat;
        @(negedge clk);
        chk(prev_tag, "line_state", line_state, m_st);
        nx = m_st; nph = 0; e_cmd = 0; e_sh = 0; e_fl = 0; e_mg = 0;
        e_boff = 0; e_bdat = 0; e_moff = 0; e_mdat = 0;
        e_busy = (m_ph != 0) || (sc != 0);
        tag = "R10";
        if (m_ph != 0) begin
            tag = "R5"; e_cmd = 2; e_boff = m_poff; e_bdat = m_pdata; nx = S_SHO;
        end else if (sc != 0) begin
            tag = (op != 0) ? "R9" : ((sc == 1) ? "R6" : "R7");
            if (sc == 1) begin
                e_sh = (m_st != S_INV);
                e_fl = is_owner(m_st);
                if (m_st == S_DRT) nx = S_SHO;
                if (m_st == S_EXCL) nx = S_SHC;
            end else if (m_st == S_SHC || m_st == S_SHO) begin
                e_mg = 1; e_sh = 1; nx = S_SHC; e_moff = soff; e_mdat = sdat;
            end
        end else begin
            case (op)
                1: tag = (m_st == S_INV) ? "R10" : "R3";
                2: begin
                    if (m_st == S_EXCL || m_st == S_DRT) begin tag = "R3"; nx = S_DRT; end
                    else if (m_st == S_SHC || m_st == S_SHO) begin
                        tag = "R4"; e_cmd = 2; e_boff = off; e_bdat = dat;
                        nx = sh ? S_SHO : S_DRT;
                    end
                end
                3: if (m_st == S_INV) begin tag = "R2"; e_cmd = 1; nx = sh ? S_SHC : S_EXCL; end
                4: if (m_st == S_INV) begin
                    tag = "R5"; e_cmd = 1;
                    if (sh) begin nx = S_SHO; nph = 1; m_poff = OW'(off); m_pdata = dat; end
                    else nx = S_DRT;
                end
                5: begin tag = "R8"; if (is_owner(m_st)) e_cmd = 3; nx = S_INV; end
                default: tag = "R10";
            endcase
        end
        chk(tag, "cpu_busy", cpu_busy, e_busy);
        chk(tag, "bus_cmd", bus_cmd, e_cmd);
        chk(tag, "bus_off", bus_off, e_boff);
        chk(tag, "bus_data", bus_data, e_bdat);
        chk(tag, "snp_shared_out", snp_shared_out, e_sh);
        chk(tag, "snp_flush", snp_flush, e_fl);
        chk(tag, "merge_en", merge_en, e_mg);
        chk(tag, "merge_off", merge_off, e_moff);
        chk(tag, "merge_data", merge_data, e_mdat);
        m_st = nx; m_ph = nph; prev_tag = tag;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_c0de;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset line_state", line_state, S_INV);
        chk("R1", "reset bus_cmd", bus_cmd, 0);
        chk("R1", "reset cpu_busy", cpu_busy, 0);
        chk("R1", "reset snp_flush", snp_flush, 0);
        @(posedge clk); #1; rst = 1'b0;

        // Directed corner cases
        step(1, 0, 0, 0, 0, 0, 0);              // R10 hit while absent
        step(3, 0, 0, 0, 0, 0, 0);              // R2 fill exclusive
        step(3, 0, 0, 1, 0, 0, 0);              // R10 miss while present
        step(2, 1, 32'h11, 0, 0, 0, 0);         // R3 silent upgrade
        step(2, 5, 32'h22, 0, 1, 0, 0);         // R9 op dropped under snoop read, R6 flush
        step(2, 6, 32'hABCD, 1, 0, 0, 0);       // R4 update kept shared
        step(0, 0, 0, 0, 2, 3, 32'hBEEF);       // R7 merge to shared clean
        step(0, 0, 0, 0, 2, 4, 32'h1);          // R7 merge again
        step(2, 7, 32'h77, 0, 0, 0, 0);         // R4 alone -> dirty
        step(0, 0, 0, 0, 2, 2, 32'h9);          // R7 ignored in dirty
        step(5, 0, 0, 0, 0, 0, 0);              // R8 writeback
        step(4, 2, 32'hFACE, 1, 0, 0, 0);       // R5 read phase
        step(1, 0, 0, 0, 1, 0, 0);              // R5/R9 update phase, snoop ignored
        step(5, 0, 0, 0, 0, 0, 0);              // R8 owner writeback
        step(4, 3, 32'h5, 0, 0, 0, 0);          // R5 unshared write miss
        step(0, 0, 0, 0, 1, 0, 0);              // R6 dirty -> owner
        step(3, 0, 0, 1, 0, 0, 0);              // R10 miss while present
        step(5, 0, 0, 0, 0, 0, 0);              // R8
        step(3, 0, 0, 1, 0, 0, 0);              // R2 fill shared
        step(5, 0, 0, 0, 0, 0, 0);              // R8 silent clean drop

        // Constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            int op, sc;
            op = int'($urandom_range(0, 5));
            sc = ($urandom_range(0, 9) < 3) ? int'($urandom_range(1, 2)) : 0;
            step(op, int'($urandom_range(0, WORDS-1)), $urandom, 1'($urandom_range(0, 1)),
                 sc, int'($urandom_range(0, WORDS-1)), $urandom);
        end
        @(negedge clk);
        chk(prev_tag, "final line_state", line_state, m_st);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule